// File: doc/BRIEF.md
# Domain Access Permission Checker

This block decides whether a memory access that has already been translated may go ahead. It holds a 32-bit control word that divides into sixteen 2-bit domain modes. Each access presents a 4-bit domain number, the 2-bit access-permission (AP) code from the matching translation entry, a privileged/user flag and a read/write flag, qualified by a valid strobe. One cycle later the block gives one of three outcomes: allow, domain fault or permission fault.

The domain mode is looked up before the AP code is used. Software can therefore rewrite one control word to switch every region in a domain between unchecked, checked and fully denied, with no change to the translation tables. Each mode value sets how much of the AP code is used. A denied mode raises a domain fault whatever the AP code is. A manager mode ignores the AP code. A client mode grants or refuses the access from the AP code together with the privilege and direction of the access.

Top module: `domain_access_gate`

## Requirements
- R1: Domain number n selects control-word bits [2n+1:2n] as its mode.
- R2: Mode 2'b00 (deny) gives a domain fault for every access.
- R3: Mode 2'b10 (reserved) gives a domain fault for every access.
- R4: Mode 2'b11 (manager) allows every access, whatever the AP code, privilege or direction.
- R5: In mode 2'b01 (client), AP 2'b11 allows reads and writes in both privileged and user state.
- R6: In client mode, AP 2'b01 allows privileged accesses only. A user access gives a permission fault.
- R7: In client mode, AP 2'b10 allows every privileged access and user reads. A user write gives a permission fault.
- R8: In client mode, AP 2'b00 gives a permission fault for every access.
- R9: Reset clears the control word to zero, so every domain gives a domain fault until the word is written.
- R10: The outcome for an access appears on the outputs, together with resValid, in the cycle after the one in which accValid was high. In any other cycle resValid and all three flags are low.
- R11: Each result has exactly one of resAllow, resDomFault and resPermFault high. A domain fault takes priority over a permission fault.
- R12: A control-word write is used by an access in the next cycle. An access in the same cycle as the write still sees the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the domain control word |
| cfgWrData | input | 32 | New domain control word |
| accValid | input | 1 | Access strobe |
| accDomain | input | 4 | Domain number of the access |
| accAp | input | 2 | AP code from the translation entry |
| accPriv | input | 1 | 1 = privileged access, 0 = user access |
| accWrite | input | 1 | 1 = write, 0 = read |
| resValid | output | 1 | Result present, one cycle after accValid |
| resAllow | output | 1 | Access may proceed |
| resDomFault | output | 1 | Access refused by the domain mode |
| resPermFault | output | 1 | Access refused by the AP code in client mode |

## Verification
The hardest case to reach from the ports is a control-word write and an access landing on the same clock edge. This case separates a design that uses the old word from one that forwards the new word. The stimulus places an access in the write cycle and another access in the cycle straight after it, and the write flips the mode of the domain both accesses use between manager and deny. A one-cycle difference in when the write is used then shows up as swapped outcomes. The bench also sweeps each of the four modes against all sixteen combinations of AP code, privilege and direction, and uses a mixed control-word pattern so that a wrong field slice gives wrong results.

// File: rtl/dap_pkg.sv
package dap_pkg;

  // Width of one domain mode field; the decision logic is written for 2 bits.
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    DM_DENY    = 2'b00,
    DM_CLIENT  = 2'b01,
    DM_RSVD    = 2'b10,
    DM_MANAGER = 2'b11
  } domMode_e;

  typedef enum logic [1:0] {
    AP_NONE    = 2'b00,
    AP_PRIV    = 2'b01,
    AP_USER_RO = 2'b10,
    AP_FULL    = 2'b11
  } apCode_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic capture;
    logic allow;
    logic domFault;
    logic permFault;
  } verdictStrobes_t;

endpackage

// File: rtl/dap_control.sv
module dap_control
  import dap_pkg::*;
(
  input  logic              accValid,
  input  logic [MODE_W-1:0] selMode,
  input  logic [1:0]        accAp,
  input  logic              accPriv,
  input  logic              accWrite,
  output verdictStrobes_t   strobes
);

  domMode_e modeNow;
  apCode_e  apNow;
  logic     apGrants;

  assign modeNow = domMode_e'(selMode);
  assign apNow   = apCode_e'(accAp);

  // Client-mode permission lookup from the AP code.
  always_comb begin
    unique case (apNow)
      AP_FULL:    apGrants = 1'b1;
      AP_PRIV:    apGrants = accPriv;
      AP_USER_RO: apGrants = accPriv | ~accWrite;
      default:    apGrants = 1'b0;
    endcase
  end

  // The domain mode is decided first; a domain fault masks the AP check.
  always_comb begin
    strobes           = '0;
    strobes.capture   = accValid;
    if (accValid) begin
      unique case (modeNow)
        DM_MANAGER: strobes.allow = 1'b1;
        DM_CLIENT: begin
          strobes.allow     = apGrants;
          strobes.permFault = ~apGrants;
        end
        default:    strobes.domFault = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dap_datapath.sv
module dap_datapath
  import dap_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int IDX_W = $clog2(NUM_DOMAINS),
  localparam int REG_W = NUM_DOMAINS * MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic [IDX_W-1:0]  accDomain,
  input  verdictStrobes_t   strobes,
  output logic [MODE_W-1:0] selMode,
  output logic              resValid,
  output logic              resAllow,
  output logic              resDomFault,
  output logic              resPermFault
);

  logic [REG_W-1:0]  ctlWord;
  logic [MODE_W-1:0] modeField [NUM_DOMAINS];

  // Domain control word; all-zero reset denies every domain.
  always_ff @(posedge clk) begin
    if (!rst_n)       ctlWord <= '0;
    else if (cfgWrEn) ctlWord <= cfgWrData;
  end

  // Slice the word into one mode field per domain.
  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_field
    assign modeField[g] = ctlWord[g*MODE_W +: MODE_W];
  end

  assign selMode = modeField[accDomain];

  // Result register, one cycle after the strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid     <= 1'b0;
      resAllow     <= 1'b0;
      resDomFault  <= 1'b0;
      resPermFault <= 1'b0;
    end else begin
      resValid     <= strobes.capture;
      resAllow     <= strobes.capture & strobes.allow;
      resDomFault  <= strobes.capture & strobes.domFault;
      resPermFault <= strobes.capture & strobes.permFault;
    end
  end

  // R11: a result carries exactly one outcome.
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> $countones({resAllow, resDomFault, resPermFault}) == 1);

  // R10: flags stay low without a result.
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> !(resAllow | resDomFault | resPermFault));

  // R12: a write is in the word one edge later.
  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrEn |=> ctlWord == $past(cfgWrData));

  // R4: the manager mode seen by the access leads to allow.
  p_manager_allow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && selMode == DM_MANAGER) |=> resAllow);

  // R2 / R3: an even mode value seen by the access leads to a domain fault.
  p_even_mode_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && !selMode[0]) |=> resDomFault);

endmodule

// File: rtl/domain_access_gate.sv
module domain_access_gate
  import dap_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int IDX_W = $clog2(NUM_DOMAINS),
  localparam int REG_W = NUM_DOMAINS * MODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             accValid,
  input  logic [IDX_W-1:0] accDomain,
  input  logic [1:0]       accAp,
  input  logic             accPriv,
  input  logic             accWrite,
  output logic             resValid,
  output logic             resAllow,
  output logic             resDomFault,
  output logic             resPermFault
);

  verdictStrobes_t   strobes;
  logic [MODE_W-1:0] selMode;

  dap_control u_ctrl (
    .accValid (accValid),
    .selMode  (selMode),
    .accAp    (accAp),
    .accPriv  (accPriv),
    .accWrite (accWrite),
    .strobes  (strobes)
  );

  dap_datapath #(.NUM_DOMAINS(NUM_DOMAINS)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .accDomain    (accDomain),
    .strobes      (strobes),
    .selMode      (selMode),
    .resValid     (resValid),
    .resAllow     (resAllow),
    .resDomFault  (resDomFault),
    .resPermFault (resPermFault)
  );

  // R10: a result follows each strobe by exactly one cycle.
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> resValid);

endmodule

// File: tb/tb_domain_access_gate.sv
module tb_domain_access_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        accValid = 1'b0;
  logic [3:0]  accDomain = '0;
  logic [1:0]  accAp = '0;
  logic        accPriv = 1'b0;
  logic        accWrite = 1'b0;
  logic        resValid, resAllow, resDomFault, resPermFault;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow = '0;

  typedef struct {
    logic [2:0] outcome; // {allow, domFault, permFault}
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  domain_access_gate dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .accValid(accValid), .accDomain(accDomain), .accAp(accAp),
    .accPriv(accPriv), .accWrite(accWrite), .resValid(resValid),
    .resAllow(resAllow), .resDomFault(resDomFault), .resPermFault(resPermFault)
  );

  // Reference model written from the requirements.
  function automatic logic [2:0] model(input logic [1:0] mode, input logic [1:0] ap,
                                       input logic priv, input logic wr);
    logic ok;
    if (mode == 2'b11) return 3'b100;
    if (mode != 2'b01) return 3'b010;
    case (ap)
      2'b11:   ok = 1'b1;
      2'b01:   ok = priv;
      2'b10:   ok = priv | ~wr;
      default: ok = 1'b0;
    endcase
    return ok ? 3'b100 : 3'b001;
  endfunction

  function automatic string reqFor(input logic [1:0] mode, input logic [1:0] ap);
    case (mode)
      2'b00: return "R2";
      2'b10: return "R3";
      2'b11: return "R4";
      default: case (ap)
        2'b11: return "R5";
        2'b01: return "R6";
        2'b10: return "R7";
        default: return "R8";
      endcase
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Driver: one access per call, at the falling edge; optional write in the same cycle.
  task automatic drive(input logic [3:0] dom, input logic [1:0] ap, input logic priv,
                       input logic wr, input string req,
                       input logic doWr = 1'b0, input logic [31:0] wrVal = '0);
    expItem_t it;
    @(negedge clk);
    it.outcome = model(shadow[dom*2 +: 2], ap, priv, wr);
    it.req     = req;
    expQ.push_back(it);
    accValid = 1'b1; accDomain = dom; accAp = ap; accPriv = priv; accWrite = wr;
    cfgWrEn = doWr; cfgWrData = wrVal;
    if (doWr) shadow = wrVal;
  endtask

  task automatic writeCfg(input logic [31:0] val);
    @(negedge clk);
    accValid = 1'b0; cfgWrEn = 1'b1; cfgWrData = val;
    shadow = val;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accValid = 1'b0; cfgWrEn = 1'b0;
    end
  endtask

  // Monitor: pops and compares each result away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (resValid) begin
        if (expQ.size() == 0) begin
          check("R10", {resValid, resAllow, resDomFault, resPermFault}, 4'b0000);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.req, {1'b1, resAllow, resDomFault, resPermFault}, {1'b1, it.outcome});
        end
      end else if (resAllow | resDomFault | resPermFault) begin
        check("R10", {resValid, resAllow, resDomFault, resPermFault}, 4'b0000);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: quiet outputs after reset
    check("R10", {resValid, resAllow, resDomFault, resPermFault}, 4'b0000);

    // R9: reset word denies every domain, even with full AP
    for (int d = 0; d < 16; d++) drive(4'(d), 2'b11, 1'b1, 1'b0, "R9");
    idle(2);

    // R1: mixed pattern, domain modes cycle deny/client/reserved/manager
    writeCfg(32'h1B1BE4E4);
    for (int d = 0; d < 16; d++) drive(4'(d), 2'b10, 1'b0, 1'b1, "R1");
    for (int d = 15; d >= 0; d--) drive(4'(d), 2'b11, 1'b0, 1'b0, "R1");
    idle(2);

    // R2..R8: each uniform mode against every AP/priv/write combination
    for (int m = 0; m < 4; m++) begin
      writeCfg({16{2'(m)}});
      for (int c = 0; c < 16; c++)
        drive(4'd5, 2'(c >> 2), c[1], c[0], reqFor(2'(m), 2'(c >> 2)));
      idle(1);
    end

    // R11: alternate outcome types back to back
    writeCfg(32'h0000_00D8); // dom0 deny, dom1 reserved, dom2 client, dom3 manager
    drive(4'd0, 2'b11, 1'b1, 1'b1, "R11");
    drive(4'd2, 2'b00, 1'b1, 1'b0, "R11");
    drive(4'd3, 2'b00, 1'b0, 1'b1, "R11");
    drive(4'd1, 2'b00, 1'b0, 1'b0, "R11");
    drive(4'd2, 2'b11, 1'b0, 1'b1, "R11");
    idle(2);

    // R12: write-then-access and write-with-access on domain 7
    writeCfg(32'h0000_C000);              // dom7 manager
    drive(4'd7, 2'b00, 1'b0, 1'b1, "R12"); // next cycle: allow
    drive(4'd7, 2'b00, 1'b0, 1'b1, "R12", 1'b1, 32'h0); // same cycle: old word, allow
    drive(4'd7, 2'b00, 1'b0, 1'b1, "R12"); // now denied: domain fault
    drive(4'd7, 2'b00, 1'b0, 1'b1, "R12", 1'b1, 32'h0000_4000); // old word: fault
    drive(4'd7, 2'b01, 1'b0, 1'b0, "R12"); // client, AP priv-only, user: perm fault
    idle(4);

    // R10: every access produced exactly one result
    check("R10", {28'd0, 4'(expQ.size())}, 32'd0);
    check("R10", {resValid, resAllow, resDomFault, resPermFault}, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule